// File: doc/BRIEF.md
# Preamble and Header Framer

This block is the transmit-side framer that produces the physical-layer preamble and header of a packet as a single serial bit stream, one bit per accepted transfer. A one-cycle start request latches a set of configuration values. These are the mode select (long or short), the sync length in symbols, and the signal byte, service byte and 16-bit length word. The framer then emits, in order, the sync run, the 16-bit start-frame delimiter, the signal, service and length fields, and a CRC-16 that it computes over those fields while they go out.

The stream leaves the block before any scrambling, so the CRC covers the unscrambled bits. The downstream scrambler and modulator pull bits through a valid/ready handshake. A rate flag travels with every bit. In short mode the flag goes high at the first header bit, so the modulator knows where to switch to double rate. A one-cycle done pulse follows the last CRC bit. A start request that arrives while a frame is in progress has no effect.

Top module: `preamble_header_framer`

## Requirements
- R1: After reset, bitValid, busy, highRate and donePulse are all low.
- R2: A startReq sampled high while busy is low latches longMode, syncLen, sigByte, svcByte and lenWord, and bitValid is high from the next cycle. A startReq while busy is high, including the cycle of the final CRC transfer, is ignored. Input changes during a frame do not alter the stream.
- R3: The frame opens with exactly syncLen sync bits. They are all ones when longMode=1 and all zeros when longMode=0. With syncLen=0 the sync run is skipped.
- R4: The delimiter is 16 bits taken from the pattern 16'hF3A0. In long mode bit 0 goes first, up to bit 15. In short mode the order is reversed, from bit 15 down to bit 0.
- R5: After the delimiter come sigByte, then svcByte, then lenWord, each sent LSB first (32 bits).
- R6: The last 16 bits are a CRC with polynomial 16'h1021 (x^16+x^12+x^5+1). The CRC register is preset to 16'hFFFF, and the 32 header bits are fed to it in transmit order. The result is complemented and sent MSB first.
- R7: highRate is high on exactly the header and CRC bits of a short-mode frame. It is low on the sync and delimiter bits, and it is always low in long mode.
- R8: A bit transfers on a clock edge where bitValid and bitReady are both high. While bitValid is high and bitReady is low, bitOut and highRate hold their values.
- R9: donePulse is high for exactly one cycle, in the cycle after the final CRC transfer. busy and bitValid are low in that cycle. A frame holds syncLen+64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a frame |
| longMode | input | 1 | 1 = long preamble, 0 = short preamble |
| syncLen | input | SYNC_LEN_W | Sync run length in symbols |
| sigByte | input | 8 | Signal field value |
| svcByte | input | 8 | Service field value |
| lenWord | input | 16 | Length field value |
| bitReady | input | 1 | Downstream accepts the current bit |
| bitOut | output | 1 | Current serial bit |
| bitValid | output | 1 | bitOut holds a frame bit |
| highRate | output | 1 | Current bit belongs to the double-rate portion |
| busy | output | 1 | A frame is in progress |
| donePulse | output | 1 | One-cycle pulse after the final bit |

## Verification
Two events can fall in the same cycle: a new start request and the transfer of the final CRC bit, which is also the cycle that ends the frame. The bench raises startReq in exactly the cycle in which it hands over the last bit. The request must be ignored. In the next cycle donePulse must be high while busy and bitValid are low. A second directed packet repeats start requests in the middle of a frame with every configuration input changed, and the emitted stream must still match the one computed from the latched values.

// File: rtl/phf_pkg.sv
package phf_pkg;
  localparam int SFD_W  = 16;
  localparam int HDR_W  = 32;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
  localparam int SFD_IDX_W = $clog2(SFD_W);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_SFD,
    PH_HDR,
    PH_CRC
  } phase_t;

  typedef struct packed {
    logic                 load;
    logic                 shiftHdr;
    logic                 shiftCrc;
    phase_t               phase;
    logic [SFD_IDX_W-1:0] sfdIdx;
  } strobe_t;
endpackage

// File: rtl/phf_ctrl.sv
module phf_ctrl
  import phf_pkg::*;
#(
  parameter int SYNC_LEN_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic [SYNC_LEN_W-1:0] syncLen,
  input  logic                  bitReady,
  output strobe_t               strobes,
  output logic                  bitValid,
  output logic                  busy,
  output logic                  donePulse
);
  localparam int HDR_CNT_W = $clog2(HDR_W) + 1;
  localparam int CNT_W = (SYNC_LEN_W > HDR_CNT_W) ? SYNC_LEN_W : HDR_CNT_W;

  phase_t                  phaseQ;
  logic [CNT_W-1:0]        cntQ;
  logic [CNT_W-1:0]        lastIdx;
  logic [SYNC_LEN_W-1:0]   syncLenQ;
  logic                    doneQ;
  logic                    fire;
  logic                    atLast;

  assign bitValid = (phaseQ != PH_IDLE);
  assign busy     = bitValid;
  assign fire     = bitValid && bitReady;
  assign atLast   = (cntQ == lastIdx);

  always_comb begin
    case (phaseQ)
      PH_SYNC: lastIdx = CNT_W'(syncLenQ) - CNT_W'(1);
      PH_SFD:  lastIdx = CNT_W'(SFD_W - 1);
      PH_HDR:  lastIdx = CNT_W'(HDR_W - 1);
      PH_CRC:  lastIdx = CNT_W'(CRC_W - 1);
      default: lastIdx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      cntQ     <= '0;
      syncLenQ <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (phaseQ == PH_IDLE) begin
        if (startReq) begin
          syncLenQ <= syncLen;
          cntQ     <= '0;
          phaseQ   <= (syncLen == '0) ? PH_SFD : PH_SYNC;
        end
      end else if (fire) begin
        if (atLast) begin
          cntQ <= '0;
          case (phaseQ)
            PH_SYNC: phaseQ <= PH_SFD;
            PH_SFD:  phaseQ <= PH_HDR;
            PH_HDR:  phaseQ <= PH_CRC;
            default: begin
              phaseQ <= PH_IDLE;
              doneQ  <= 1'b1;
            end
          endcase
        end else begin
          cntQ <= cntQ + CNT_W'(1);
        end
      end
    end
  end

  assign donePulse = doneQ;

  always_comb begin
    strobes.load     = (phaseQ == PH_IDLE) && startReq;
    strobes.shiftHdr = fire && (phaseQ == PH_HDR);
    strobes.shiftCrc = fire && (phaseQ == PH_CRC);
    strobes.phase    = phaseQ;
    strobes.sfdIdx   = cntQ[SFD_IDX_W-1:0];
  end
endmodule

// File: rtl/phf_datapath.sv
module phf_datapath
  import phf_pkg::*;
#(
  parameter logic [SFD_W-1:0] SFD_PATTERN = 16'hF3A0
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strobes,
  input  logic        longMode,
  input  logic [7:0]  sigByte,
  input  logic [7:0]  svcByte,
  input  logic [15:0] lenWord,
  output logic        bitOut,
  output logic        highRate
);
  logic               longQ;
  logic [HDR_W-1:0]   hdrShift;
  logic [CRC_W-1:0]   crcQ;
  logic               crcFb;
  logic [SFD_W-1:0]   sfdOrdered;

  // Short mode sends the delimiter in reverse order: build the reversed copy.
  for (genvar g = 0; g < SFD_W; g++) begin : g_sfdOrder
    assign sfdOrdered[g] = longQ ? SFD_PATTERN[g] : SFD_PATTERN[SFD_W-1-g];
  end

  assign crcFb = crcQ[CRC_W-1] ^ hdrShift[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      longQ    <= 1'b1;
      hdrShift <= '0;
      crcQ     <= CRC_PRESET;
    end else if (strobes.load) begin
      longQ    <= longMode;
      hdrShift <= {lenWord, svcByte, sigByte};
      crcQ     <= CRC_PRESET;
    end else if (strobes.shiftHdr) begin
      hdrShift <= {1'b0, hdrShift[HDR_W-1:1]};
      crcQ     <= {crcQ[CRC_W-2:0], 1'b0} ^ (crcFb ? CRC_POLY : '0);
    end else if (strobes.shiftCrc) begin
      crcQ     <= {crcQ[CRC_W-2:0], 1'b0};
    end
  end

  always_comb begin
    case (strobes.phase)
      PH_SYNC: bitOut = longQ;
      PH_SFD:  bitOut = sfdOrdered[strobes.sfdIdx];
      PH_HDR:  bitOut = hdrShift[0];
      PH_CRC:  bitOut = ~crcQ[CRC_W-1];
      default: bitOut = 1'b0;
    endcase
  end

  assign highRate = !longQ && ((strobes.phase == PH_HDR) || (strobes.phase == PH_CRC));
endmodule

// File: rtl/preamble_header_framer.sv
module preamble_header_framer
  import phf_pkg::*;
#(
  parameter int SYNC_LEN_W = 8,
  parameter logic [15:0] SFD_PATTERN = 16'hF3A0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  longMode,
  input  logic [SYNC_LEN_W-1:0] syncLen,
  input  logic [7:0]            sigByte,
  input  logic [7:0]            svcByte,
  input  logic [15:0]           lenWord,
  input  logic                  bitReady,
  output logic                  bitOut,
  output logic                  bitValid,
  output logic                  highRate,
  output logic                  busy,
  output logic                  donePulse
);
  strobe_t strobes;

  phf_ctrl #(.SYNC_LEN_W(SYNC_LEN_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .syncLen   (syncLen),
    .bitReady  (bitReady),
    .strobes   (strobes),
    .bitValid  (bitValid),
    .busy      (busy),
    .donePulse (donePulse)
  );

  phf_datapath #(.SFD_PATTERN(SFD_PATTERN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .longMode (longMode),
    .sigByte  (sigByte),
    .svcByte  (svcByte),
    .lenWord  (lenWord),
    .bitOut   (bitOut),
    .highRate (highRate)
  );
endmodule

// File: rtl/phf_checker.sv
module phf_checker (
  input logic clk,
  input logic rstN,
  input logic bitOut,
  input logic bitValid,
  input logic bitReady,
  input logic highRate,
  input logic busy,
  input logic donePulse
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!bitValid && !highRate));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !bitReady) |=> (bitValid && $stable(bitOut) && $stable(highRate)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_done_after_xfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(bitValid && bitReady)));

  assert_rate_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highRate) |-> $past(bitValid && bitReady));
endmodule

bind preamble_header_framer phf_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bitOut    (bitOut),
  .bitValid  (bitValid),
  .bitReady  (bitReady),
  .highRate  (highRate),
  .busy      (busy),
  .donePulse (donePulse)
);

// File: tb/test_preamble_header_framer.sv
module test_preamble_header_framer;
  localparam logic [15:0] PAT = 16'hF3A0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        longMode = 1'b1;
  logic [7:0]  syncLen = 8'd0;
  logic [7:0]  sigByte = 8'd0;
  logic [7:0]  svcByte = 8'd0;
  logic [15:0] lenWord = 16'd0;
  logic        bitReady = 1'b0;
  logic        bitOut, bitValid, highRate, busy, donePulse;

  int checks = 0;
  int errors = 0;
  logic expBit  [0:400];
  logic expHigh [0:400];
  int   expN;

  always #10 clk = ~clk;

  preamble_header_framer i_preamble_header_framer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .longMode(longMode),
    .syncLen(syncLen), .sigByte(sigByte), .svcByte(svcByte), .lenWord(lenWord),
    .bitReady(bitReady), .bitOut(bitOut), .bitValid(bitValid),
    .highRate(highRate), .busy(busy), .donePulse(donePulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] refCrc(input logic [31:0] hdr);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic fb = c[15] ^ hdr[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return ~c;
  endfunction

  task automatic buildExpected(input logic lm, input int sl, input logic [7:0] sg,
                               input logic [7:0] sv, input logic [15:0] ln);
    logic [31:0] hdr = {ln, sv, sg};
    logic [15:0] crc = refCrc({ln, sv, sg});
    int k = 0;
    for (int i = 0; i < sl; i++) begin expBit[k] = lm; expHigh[k] = 1'b0; k++; end
    for (int i = 0; i < 16; i++) begin
      expBit[k] = lm ? PAT[i] : PAT[15-i]; expHigh[k] = 1'b0; k++;
    end
    for (int i = 0; i < 32; i++) begin expBit[k] = hdr[i]; expHigh[k] = !lm; k++; end
    for (int i = 15; i >= 0; i--) begin expBit[k] = crc[i]; expHigh[k] = !lm; k++; end
    expN = k;
  endtask

  function automatic string regionReq(input int idx, input int sl);
    if (idx < sl) return "R3";
    if (idx < sl + 16) return "R4";
    if (idx < sl + 48) return "R5";
    return "R6";
  endfunction

  task automatic runPacket(input logic lm, input int sl, input logic [7:0] sg,
                           input logic [7:0] sv, input logic [15:0] ln,
                           input bit midStart, input bit endStart);
    int n = 0;
    int guard = 0;
    buildExpected(lm, sl, sg, sv, ln);
    @(negedge clk);
    longMode = lm; syncLen = 8'(sl); sigByte = sg; svcByte = sv; lenWord = ln;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(bitValid === 1'b1 && busy === 1'b1, "R2", "valid after start", int'(bitValid), 1);
    while (n < expN && guard < 5000) begin
      guard++;
      startReq = 1'b0;
      bitReady = ($urandom % 4) != 0;
      #1;
      if (!bitValid || donePulse) begin
        check(1'b0, "R9", "valid during frame", int'(bitValid), 1);
      end
      if (bitValid && bitReady) begin
        check(bitOut === expBit[n], regionReq(n, sl), "bit value", int'(bitOut), int'(expBit[n]));
        check(highRate === expHigh[n], "R7", "rate flag", int'(highRate), int'(expHigh[n]));
        n++;
        if (n == expN && endStart) startReq = 1'b1;   // R2: start on final transfer
      end
      if (midStart && n >= 20 && n < 30) begin       // R2: ignored while busy
        startReq = 1'b1;
        longMode = ~lm; syncLen = 8'd3; sigByte = ~sg; svcByte = ~sv; lenWord = ~ln;
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    bitReady = 1'b0;
    check(n == expN, "R9", "bit count", n, expN);
    #1;
    check(donePulse === 1'b1, "R9", "done pulse", int'(donePulse), 1);
    check(busy === 1'b0 && bitValid === 1'b0, endStart ? "R2" : "R9",
          "idle at done", int'(busy), 0);
    @(negedge clk);
    #1;
    check(donePulse === 1'b0, "R9", "done single", int'(donePulse), 0);
    check(bitValid === 1'b0, "R2", "no restart", int'(bitValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    #1;
    check(bitValid === 1'b0 && busy === 1'b0 && donePulse === 1'b0 && highRate === 1'b0,
          "R1", "reset outputs", int'(bitValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(bitValid === 1'b0 && busy === 1'b0, "R1", "idle after reset", int'(busy), 0);
    runPacket(1'b1, 128, 8'h0A, 8'h04, 16'h0123, 1'b0, 1'b0);
    runPacket(1'b0, 56, 8'h14, 8'h00, 16'h00FF, 1'b0, 1'b0);
    runPacket(1'b1, 0, 8'hA5, 8'h5A, 16'hFFFF, 1'b0, 1'b0);
    runPacket(1'b0, 1, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1);
    runPacket(1'b0, 40, 8'h6E, 8'h80, 16'h1234, 1'b1, 1'b0);
    runPacket(1'b1, 255, 8'hFF, 8'hFF, 16'h8001, 1'b0, 1'b0);
    for (int p = 0; p < 8; p++) begin
      runPacket(1'($urandom % 2), int'($urandom % 160), 8'($urandom), 8'($urandom),
                16'($urandom), 1'b0, 1'($urandom % 2));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule